// File: doc/BRIEF.md
# Product Term Sharing Array

This block sits between a programmable AND array and a bank of macrocells. It receives the product terms of a logic block, arranged in fixed-size groups, and produces one sum-of-products output for each macrocell. An output can work in one of two ways. It can take its own group directly through a bypass path. Or it can OR together a contiguous run of neighbouring groups, starting at an offset from its own index and wrapping past the last group back to group zero.

Each output then passes through an XOR stage, which can invert the sum. The configuration is static and is applied as one byte per output. A group may feed only one output, so the block flags any configuration in which two outputs claim the same group, and any configuration that uses an invalid offset. The block is purely combinational.

Top module: `pt_share_array`

## Requirements
- R1: In sharing mode (bypass clear, start offset 0 to 6, span nonzero), output o is the OR of all terms in groups (o+start) through (o+start+span-1), XORed with the output's invert bit. Group g occupies pt_in[5g+4:5g].
- R2: Group indices wrap modulo 32, so a run that begins near output 31 continues into group 0 and upward.
- R3: The configuration byte for output o is cfg_in[8o+7:8o]. Bits 2:0 hold the span (0 to 7 groups), bits 5:3 hold the start offset, bit 6 is bypass and bit 7 is invert. A single output can therefore collect up to 35 terms.
- R4: With bypass set, output o is the OR of its own group o only, XORed with invert, and the start and span fields have no effect.
- R5: The invert bit complements the output in every mode.
- R6: An output with bypass clear and span 0 claims no groups and drives its invert bit.
- R7: config_error is high whenever any group is claimed by more than one output. A bypassed output claims its own group.
- R8: A start offset of 7 with bypass clear is invalid. It raises config_error, and that output claims no groups and drives its invert bit.
- R9: The outputs and config_error follow the inputs combinationally, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pt_in | input | 160 | Product terms, 32 groups of five |
| cfg_in | input | 256 | Per-output configuration bytes |
| sop_out | output | 32 | Sum-of-products output per macrocell |
| config_error | output | 1 | Group conflict or invalid offset |

## Verification
The bench builds the block with its default parameters: 32 groups of five terms, with a 3-bit offset field and a 3-bit span field. These values bring several corner cases within reach. Output 31 running a seven-group span that wraps through group 0. The largest run, offset 6 with span 7. The single invalid offset value 7. Random sparse configurations, which produce both conflict-free and conflicting allocations against the bench model.

// File: rtl/pt_share_array.sv
module pt_share_array #(
  parameter int NGRP   = 32,
  parameter int GTERMS = 5,
  parameter int OFFW   = 3,
  parameter int SPANW  = 3
) (
  input  logic [NGRP*GTERMS-1:0]      pt_in,
  input  logic [NGRP*(OFFW+SPANW+2)-1:0] cfg_in,
  output logic [NGRP-1:0]             sop_out,
  output logic                        config_error
);
  localparam int CFGW  = OFFW + SPANW + 2;
  localparam int MAXST = (1 << OFFW) - 2;

  logic [NGRP-1:0]      grp_any;
  logic [NGRP-1:0]      byp, inv, st_bad;
  logic [NGRP*NGRP-1:0] claim;
  logic [NGRP*NGRP-1:0] col;
  logic [NGRP-1:0]      conf_bad;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign grp_any[g] = |pt_in[g*GTERMS +: GTERMS];
  end

  for (genvar o = 0; o < NGRP; o++) begin : g_out
    logic [CFGW-1:0]  c;
    logic [SPANW-1:0] span;
    logic [OFFW-1:0]  st;
    assign c      = cfg_in[o*CFGW +: CFGW];
    assign span   = c[SPANW-1:0];
    assign st     = c[SPANW +: OFFW];
    assign byp[o] = c[CFGW-2];
    assign inv[o] = c[CFGW-1];
    assign st_bad[o] = !byp[o] && (int'(st) > MAXST);

    for (genvar g = 0; g < NGRP; g++) begin : g_cl
      localparam int DIST = (g - o + NGRP) % NGRP;
      assign claim[o*NGRP+g] = byp[o] ? (DIST == 0)
                             : (!st_bad[o] && DIST >= int'(st) &&
                                DIST < int'(st) + int'(span));
      assign col[g*NGRP+o] = claim[o*NGRP+g];
    end

    assign sop_out[o] = (|(claim[o*NGRP +: NGRP] & grp_any)) ^ inv[o];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_conf
    logic [NGRP-1:0] cv;
    assign cv = col[g*NGRP +: NGRP];
    assign conf_bad[g] = |(cv & (cv - 1'b1));
  end

  assign config_error = (|conf_bad) | (|st_bad);
endmodule

// File: rtl/pt_share_array_checks.sv
module pt_share_array_checks #(
  parameter int NGRP   = 32,
  parameter int GTERMS = 5,
  parameter int OFFW   = 3,
  parameter int SPANW  = 3
) (
  input logic [NGRP*GTERMS-1:0]         pt_in,
  input logic [NGRP*(OFFW+SPANW+2)-1:0] cfg_in,
  input logic [NGRP-1:0]                sop_out,
  input logic                           config_error
);
  localparam int CFGW = OFFW + SPANW + 2;

  always_comb begin
    for (int o = 0; o < NGRP; o++) begin
      logic [CFGW-1:0] c, cn;
      logic [SPANW-1:0] sp;
      logic [OFFW-1:0] st;
      c  = cfg_in[o*CFGW +: CFGW];
      cn = cfg_in[((o+1)%NGRP)*CFGW +: CFGW];
      sp = c[SPANW-1:0];
      st = c[SPANW +: OFFW];
      if (c[CFGW-2])
        a_r4_bypass_own: assert (sop_out[o] == ((|pt_in[o*GTERMS +: GTERMS]) ^ c[CFGW-1]));
      if (!c[CFGW-2] && sp == '0)
        a_r6_idle_invert: assert (sop_out[o] == c[CFGW-1]);
      if (!c[CFGW-2] && st == '0 && int'(sp) >= 2 && cn[CFGW-2])
        a_r7_conflict_flag: assert (config_error);
      if (!c[CFGW-2] && st == '1)
        a_r8_bad_offset: assert (config_error && sop_out[o] == c[CFGW-1]);
      if (!c[CFGW-2] && int'(sp) == 1 && st != '1)
        a_r1_single_group: assert (sop_out[o] ==
          ((|pt_in[((o + int'(st)) % NGRP)*GTERMS +: GTERMS]) ^ c[CFGW-1]));
    end
    if (pt_in == '0)
      for (int o = 0; o < NGRP; o++)
        a_r5_zero_terms: assert (sop_out[o] == cfg_in[o*CFGW + CFGW-1]);
  end
endmodule

bind pt_share_array pt_share_array_checks #(
  .NGRP(NGRP), .GTERMS(GTERMS), .OFFW(OFFW), .SPANW(SPANW)
) u_checks (
  .pt_in(pt_in), .cfg_in(cfg_in), .sop_out(sop_out), .config_error(config_error)
);

// File: tb/test_pt_share_array.sv
module test_pt_share_array;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [159:0] pt;
  logic [255:0] cfg;
  logic [31:0]  sop;
  logic         err;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  pt_share_array i_pt_share_array (.pt_in(pt), .cfg_in(cfg), .sop_out(sop), .config_error(err));

  function automatic void model(input logic [159:0] p, input logic [255:0] c,
                                output logic [31:0] o_exp, output logic e_exp);
    int cnt [32];
    e_exp = 1'b0;
    for (int g = 0; g < 32; g++) cnt[g] = 0;
    for (int o = 0; o < 32; o++) begin
      logic [7:0] b;
      logic acc;
      b = c[o*8 +: 8];
      acc = 1'b0;
      if (b[6]) begin
        cnt[o]++;
        acc = |p[o*5 +: 5];
      end else if (b[5:3] == 3'd7) begin
        e_exp = 1'b1;
      end else begin
        for (int k = 0; k < int'(b[2:0]); k++) begin
          int g;
          g = (o + int'(b[5:3]) + k) % 32;
          cnt[g]++;
          acc = acc | (|p[g*5 +: 5]);
        end
      end
      o_exp[o] = acc ^ b[7];
    end
    for (int g = 0; g < 32; g++) if (cnt[g] > 1) e_exp = 1'b1;
  endfunction

  function automatic logic [7:0] cb(input bit invb, input bit bp, input int st, input int sp);
    return {invb, bp, 3'(st), 3'(sp)};
  endfunction

  task automatic apply(input logic [159:0] p, input logic [255:0] c, input string req);
    logic [31:0] oe;
    logic ee;
    @(posedge clk);
    pt = p; cfg = c;
    @(negedge clk);
    model(p, c, oe, ee);
    n_run++;
    if (sop !== oe || err !== ee) begin
      n_fail++;
      $display("FAIL %s: sop=%h err=%b expected sop=%h err=%b", req, sop, err, oe, ee);
    end
  endtask

  task automatic check_bit(input int idx, input logic expv, input string req);
    n_run++;
    if (sop[idx] !== expv) begin
      n_fail++;
      $display("FAIL %s: sop[%0d]=%b expected %b", req, idx, sop[idx], expv);
    end
  endtask

  task automatic check_err(input logic expv, input string req);
    n_run++;
    if (err !== expv) begin
      n_fail++;
      $display("FAIL %s: config_error=%b expected %b", req, err, expv);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [255:0] c;
    logic [159:0] p;
    void'($urandom(32'd2024));
    pt = '0; cfg = '0;

    // R9 R6: all-idle configuration gives zeros, no error
    apply('0, '0, "R6 R9 idle zero");
    check_err(1'b0, "R7 idle no error");

    // R5 R6: idle outputs all inverted
    c = '0;
    for (int o = 0; o < 32; o++) c[o*8 +: 8] = cb(1, 0, 0, 0);
    apply({160{1'b1}}, c, "R5 R6 idle invert");
    check_bit(9, 1'b1, "R6 idle drives invert");

    // R2 R3: output 31 span 7 wraps into group 3
    c = '0; c[31*8 +: 8] = cb(0, 0, 0, 7);
    p = '0; p[3*5 + 2] = 1'b1;
    apply(p, c, "R2 wrap span7");
    check_bit(31, 1'b1, "R2 wrap reaches group 3");
    check_err(1'b0, "R2 no conflict");

    // R3: offset 6 span 7 from output 0 reaches group 12 but not 13
    c = '0; c[0 +: 8] = cb(0, 0, 6, 7);
    p = '0; p[12*5] = 1'b1;
    apply(p, c, "R3 max run end");
    check_bit(0, 1'b1, "R3 group 12 included");
    p = '0; p[13*5] = 1'b1;
    apply(p, c, "R3 beyond run");
    check_bit(0, 1'b0, "R3 group 13 excluded");

    // R4: bypass ignores start/span and uses own group
    c = '0; c[5*8 +: 8] = cb(0, 1, 3, 7);
    p = '0; p[8*5] = 1'b1;
    apply(p, c, "R4 bypass ignores run");
    check_bit(5, 1'b0, "R4 bypass not fed by group 8");
    p = '0; p[5*5 + 4] = 1'b1;
    apply(p, c, "R4 bypass own group");
    check_bit(5, 1'b1, "R4 own group");

    // R7: sharing run overlaps bypassed neighbour
    c = '0; c[4*8 +: 8] = cb(0, 0, 0, 2); c[5*8 +: 8] = cb(0, 1, 0, 0);
    apply('0, c, "R7 overlap bypass");
    check_err(1'b1, "R7 conflict");

    // R8: invalid start offset
    c = '0; c[10*8 +: 8] = cb(1, 0, 7, 3);
    apply({160{1'b1}}, c, "R8 bad offset");
    check_err(1'b1, "R8 error raised");
    check_bit(10, 1'b1, "R8 output drives invert");

    // R1 R5: random sparse and fully random configurations
    for (int t = 0; t < 300; t++) begin
      c = '0;
      for (int o = 0; o < 32; o++) begin
        int r;
        r = $urandom_range(0, 9);
        if (r < 6)       c[o*8 +: 8] = cb(1'($urandom), 0, 0, 0);
        else if (r < 8)  c[o*8 +: 8] = cb(1'($urandom), 1, $urandom_range(0,7), $urandom_range(0,7));
        else             c[o*8 +: 8] = cb(1'($urandom), 0, $urandom_range(0,6), $urandom_range(1,7));
      end
      if (t % 10 == 0) for (int w = 0; w < 8; w++) c[w*32 +: 32] = $urandom;
      for (int w = 0; w < 5; w++) p[w*32 +: 32] = $urandom & $urandom & $urandom;
      apply(p, c, "R1 R5 R7 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule